// File: doc/BRIEF.md
# Multi-Band Spectral Energy Extractor

This block takes one channel of signed 12-bit samples, nominally at 600 Hz, and gives out a vector of seven band energies once per analysis window. Every sample goes into a 49-tap history line. After every eighth accepted sample, one low-pass FIR pass runs over that history. The pass yields one decimated sample, nominally at 75 Hz, which is pushed into a 47-tap history line. Seven band-pass FIR passes then run over the second line, one for each band. The magnitude of each band output is added into that band's 16-bit saturating energy bin. After `WIN_LEN` decimated samples (150 by default, which is two seconds) the seven bins are copied to the output, a one-cycle valid pulse is raised and the bins restart from zero.

All filter passes share one multiply-accumulate unit and run one tap per clock. A controller sequences them with four states. `S_IDLE` accepts samples. `S_DEC` runs the decimator pass. `S_BAND` runs the seven band passes one after another. `S_FRAME` publishes the window and clears the bins. The transitions are:
- idle→dec: the eighth sample of a group is accepted.
- dec→band: the last decimator tap has been reached.
- band→band: a band that is not the last finishes.
- band→idle: the last band finishes and the window is not yet full.
- band→frame: the last band finishes and the window is full.
- frame→idle: always.

Coefficients live in internal registers and are written through a tap-addressed write port. The write port selects the filter by bank number: bank 0 holds the low-pass decimator, and banks 1 to 7 hold the band filters in ascending order.

Top module: `band_energy_frame`

## Requirements
- R1: After reset `in_ready` is 1, `frame_valid` is 0, `frame_bins` is all zero, every coefficient is zero and both history lines hold zeros.
- R2: `in_ready` stays 1 after each of the first seven accepted samples of a group. It is 0 in the cycle after the eighth accepted sample, and only that sample starts a filter pass.
- R3: The decimated sample is computed when a group completes as d = sat12((Σ_{k=0..48} c0[k]·x[n−k]) >>> 7). Here x[n] is the newest accepted sample, the shift is arithmetic, and sat12 clamps the result to the range −2048..2047.
- R4: For bank b in 1..7, the band output is y_b = (Σ_{k=0..46} cb[k]·d[m−k]) >>> 7 at full precision, where d[m] is the newest decimated sample. Bin b−1 then gains |y_b|.
- R5: An energy bin saturates at 65535 and stays there until it is cleared.
- R6: After every `WIN_LEN` decimated samples, `frame_valid` is high for exactly one cycle. At the same time `frame_bins[16*(b−1) +: 16]` carries the bin of bank b. `frame_bins` does not change outside that pulse.
- R7: All bins clear when a window is published, so each frame covers only its own window.
- R8: While `in_ready` is 0 no sample is taken. A source that holds `in_valid` and `in_data` through that time has its sample accepted once `in_ready` returns, and nothing is lost.
- R9: A write with `coef_we` high stores `coef_data` as tap `coef_tap` of bank `coef_bank`, and later passes use it. Taps 0..48 are used in bank 0 and taps 0..46 in banks 1..7. With the reset coefficients of zero, every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be taken this cycle |
| in_data | input | 12 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_bank | input | 3 | Filter bank (0 decimator, 1..7 bands) |
| coef_tap | input | 6 | Tap index within the bank |
| coef_data | input | 8 | Signed coefficient value |
| frame_valid | output | 1 | One-cycle window-complete pulse |
| frame_bins | output | 112 | Seven 16-bit energy bins, bank 1 in the low bits |

## Verification
The assertions assume that a source seeing `in_ready` low keeps its sample waiting and does not withdraw it. They also assume that coefficient writes happen only while the block is idle, so no pass mixes old and new taps. The stimulus meets both conditions. It sends samples at random moments and holds each one until it is taken. Before any coefficient write it waits for `in_ready` to be high, and it issues no new sample during the writes. Random samples and coefficients are mixed with full-scale and alternating-sign runs that drive both the decimator clamp and the bin saturation.

// File: rtl/bef_pkg.sv
package bef_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_DEC,
        S_BAND,
        S_FRAME
    } bef_state_e;
endpackage

// File: rtl/bef_coef_bank.sv
module bef_coef_bank #(
    parameter int BANKS  = 8,
    parameter int TAPS   = 49,
    parameter int COEF_W = 8,
    parameter int BANK_W = 3,
    parameter int TAP_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [BANK_W-1:0]        wbank,
    input  logic [TAP_W-1:0]         wtap,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [BANK_W-1:0]        rbank,
    input  logic [TAP_W-1:0]         rtap,
    output logic signed [COEF_W-1:0] rdata
);
    logic signed [COEF_W-1:0] mem [BANKS][TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++)
                for (int t = 0; t < TAPS; t++)
                    mem[b][t] <= '0;
        end else if (we && int'(wbank) < BANKS && int'(wtap) < TAPS) begin
            mem[wbank][wtap] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(rbank) < BANKS && int'(rtap) < TAPS) rdata = mem[rbank][rtap];
    end
endmodule

// File: rtl/bef_delay_line.sv
module bef_delay_line #(
    parameter int DEPTH = 49,
    parameter int W     = 12,
    parameter int SEL_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic signed [W-1:0] din,
    input  logic [SEL_W-1:0]    sel,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] line [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else if (push) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(sel) == i) dout = line[i];
    end
endmodule

// File: rtl/bef_mac.sv
module bef_mac #(
    parameter int A_W   = 12,
    parameter int B_W   = 8,
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [A_W-1:0]   a,
    input  logic signed [B_W-1:0]   b,
    output logic signed [ACC_W-1:0] sum_o
);
    logic signed [ACC_W-1:0] acc_q, a_x, b_x;

    assign a_x   = ACC_W'(a);
    assign b_x   = ACC_W'(b);
    assign sum_o = (first ? '0 : acc_q) + a_x * b_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= sum_o;
    end
endmodule

// File: rtl/band_energy_frame.sv
module band_energy_frame
    import bef_pkg::*;
#(
    parameter int SAMP_W   = 12,
    parameter int COEF_W   = 8,
    parameter int DECIM    = 8,
    parameter int DEC_TAPS = 49,
    parameter int BPF_TAPS = 47,
    parameter int NBANDS   = 7,
    parameter int BIN_W    = 16,
    parameter int WIN_LEN  = 150,
    parameter int BANK_W   = $clog2(NBANDS + 1),
    parameter int TAP_W    = $clog2(DEC_TAPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [SAMP_W-1:0]  in_data,
    input  logic                      coef_we,
    input  logic [BANK_W-1:0]         coef_bank,
    input  logic [TAP_W-1:0]          coef_tap,
    input  logic signed [COEF_W-1:0]  coef_data,
    output logic                      frame_valid,
    output logic [NBANDS*BIN_W-1:0]   frame_bins
);
    localparam int ACC_W = SAMP_W + COEF_W + $clog2(DEC_TAPS);
    localparam int FRAC  = COEF_W - 1;
    localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int WIN_W = $clog2(WIN_LEN + 1);
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(DECIM - 1);
    localparam logic [TAP_W-1:0]  DEC_LAST  = TAP_W'(DEC_TAPS - 1);
    localparam logic [TAP_W-1:0]  BPF_LAST  = TAP_W'(BPF_TAPS - 1);
    localparam logic [BANK_W-1:0] BAND_LAST = BANK_W'(NBANDS);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_LEN - 1);
    localparam logic [BIN_W-1:0]  BIN_MAX   = '1;
    localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((2 ** (SAMP_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SMIN = ~SMAX;

    bef_state_e state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [TAP_W-1:0]  tap_q;
    logic [BANK_W-1:0] band_q;
    logic [WIN_W-1:0]  win_q;
    logic [BIN_W-1:0]  energy_q [NBANDS];

    logic accept, dec_run, band_run, tap_end;
    logic signed [SAMP_W-1:0] dec_x, band_x, mac_a, dec_samp;
    logic signed [COEF_W-1:0] coef_rd;
    logic signed [ACC_W-1:0]  mac_sum, shifted, mag;
    logic [BANK_W-1:0] rd_bank;
    logic [BIN_W-1:0]  cur_bin, bin_next;
    logic [ACC_W:0]    bin_sum;

    assign in_ready = (state_q == S_IDLE);
    assign accept   = in_valid && in_ready;
    assign dec_run  = (state_q == S_DEC);
    assign band_run = (state_q == S_BAND);
    assign tap_end  = dec_run ? (tap_q == DEC_LAST) : (tap_q == BPF_LAST);
    assign rd_bank  = dec_run ? '0 : band_q;
    assign mac_a    = dec_run ? dec_x : band_x;

    bef_coef_bank #(.BANKS(NBANDS + 1), .TAPS(DEC_TAPS), .COEF_W(COEF_W),
                    .BANK_W(BANK_W), .TAP_W(TAP_W)) coef_i (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .wbank(coef_bank), .wtap(coef_tap),
        .wdata(coef_data), .rbank(rd_bank), .rtap(tap_q), .rdata(coef_rd));

    bef_delay_line #(.DEPTH(DEC_TAPS), .W(SAMP_W), .SEL_W(TAP_W)) raw_line_i (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(in_data), .sel(tap_q), .dout(dec_x));

    bef_delay_line #(.DEPTH(BPF_TAPS), .W(SAMP_W), .SEL_W(TAP_W)) dec_line_i (
        .clk(clk), .rst_n(rst_n), .push(dec_run && tap_end), .din(dec_samp),
        .sel(tap_q), .dout(band_x));

    bef_mac #(.A_W(SAMP_W), .B_W(COEF_W), .ACC_W(ACC_W)) mac_i (
        .clk(clk), .rst_n(rst_n), .en(dec_run || band_run), .first(tap_q == '0),
        .a(mac_a), .b(coef_rd), .sum_o(mac_sum));

    // scaling, clamping and magnitude of the finished pass
    always_comb begin
        shifted  = mac_sum >>> FRAC;
        dec_samp = (shifted > SMAX) ? SAMP_W'(SMAX) :
                   (shifted < SMIN) ? SAMP_W'(SMIN) : SAMP_W'(shifted);
        mag      = shifted[ACC_W-1] ? -shifted : shifted;
        cur_bin  = '0;
        for (int b = 0; b < NBANDS; b++)
            if (BANK_W'(b + 1) == band_q) cur_bin = energy_q[b];
        bin_sum  = (ACC_W + 1)'(cur_bin) + (ACC_W + 1)'(mag);
        bin_next = (bin_sum > (ACC_W + 1)'(BIN_MAX)) ? BIN_MAX : BIN_W'(bin_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept && phase_q == PH_LAST) state_d = S_DEC;
            S_DEC:   if (tap_end) state_d = S_BAND;
            S_BAND:  if (tap_end && band_q == BAND_LAST)
                         state_d = (win_q == WIN_LAST) ? S_FRAME : S_IDLE;
            S_FRAME: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            tap_q       <= '0;
            band_q      <= BANK_W'(1);
            win_q       <= '0;
            frame_valid <= 1'b0;
            frame_bins  <= '0;
            for (int b = 0; b < NBANDS; b++) energy_q[b] <= '0;
        end else begin
            frame_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: if (accept) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                S_DEC: begin
                    tap_q  <= tap_end ? '0 : tap_q + 1'b1;
                    band_q <= BANK_W'(1);
                end
                S_BAND: begin
                    if (tap_end) begin
                        tap_q <= '0;
                        for (int b = 0; b < NBANDS; b++)
                            if (BANK_W'(b + 1) == band_q) energy_q[b] <= bin_next;
                        if (band_q == BAND_LAST) begin
                            band_q <= BANK_W'(1);
                            win_q  <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
                        end else begin
                            band_q <= band_q + 1'b1;
                        end
                    end else begin
                        tap_q <= tap_q + 1'b1;
                    end
                end
                S_FRAME: begin
                    frame_valid <= 1'b1;
                    for (int b = 0; b < NBANDS; b++) begin
                        frame_bins[b*BIN_W +: BIN_W] <= energy_q[b];
                        energy_q[b] <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_bins));
    // R2
    group_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && phase_q == PH_LAST) |=> !in_ready);
    // R8
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FRAME) |=> in_ready);
    // R2
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_run |-> (tap_q <= BPF_LAST && band_q != '0 && band_q <= BAND_LAST));

    for (genvar g = 0; g < NBANDS; g++) begin : g_bin_chk
        // R7
        bin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            frame_valid |-> energy_q[g] == '0);
        // R5
        bin_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (energy_q[g] == BIN_MAX && state_q != S_FRAME) |=> energy_q[g] == BIN_MAX);
    end
endmodule

// File: tb/band_energy_frame_tb.sv
module band_energy_frame_tb_top;
    localparam int WIN = 4;
    localparam int NB  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [11:0] in_data = '0;
    logic coef_we = 1'b0;
    logic [2:0] coef_bank = '0;
    logic [5:0] coef_tap = '0;
    logic signed [7:0] coef_data = '0;
    logic frame_valid;
    logic [111:0] frame_bins;

    always #2 clk = ~clk;

    band_energy_frame #(.WIN_LEN(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .coef_we(coef_we), .coef_bank(coef_bank),
        .coef_tap(coef_tap), .coef_data(coef_data), .frame_valid(frame_valid),
        .frame_bins(frame_bins));

    int total = 0;
    int bad = 0;
    string cur_tag = "R9";

    // reference model state
    int xh [49];
    int dh [47];
    int cf [8][49];
    int en [NB];
    int ph = 0;
    int wc = 0;
    logic [111:0] exp_fr [64];
    string exp_tag [64];
    int nexp = 0;
    int ngot = 0;

    task automatic check(input bit ok, input string tag, input logic [111:0] act,
                         input logic [111:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int dec_out();
        int acc = 0;
        for (int k = 0; k < 49; k++) acc += cf[0][k] * xh[k];
        return sat12(acc >>> 7);
    endfunction

    function automatic int band_mag(input int b);
        int acc = 0;
        for (int k = 0; k < 47; k++) acc += cf[b][k] * dh[k];
        acc = acc >>> 7;
        return (acc < 0) ? -acc : acc;
    endfunction

    task automatic model_push(input int v);
        logic [111:0] fr;
        for (int k = 48; k > 0; k--) xh[k] = xh[k-1];
        xh[0] = v;
        ph++;
        if (ph == 8) begin
            ph = 0;
            for (int k = 46; k > 0; k--) dh[k] = dh[k-1];
            dh[0] = dec_out();
            for (int b = 0; b < NB; b++) begin
                en[b] = en[b] + band_mag(b + 1);
                if (en[b] > 65535) en[b] = 65535;
            end
            wc++;
            if (wc == WIN) begin
                wc = 0;
                for (int b = 0; b < NB; b++) begin
                    fr[b*16 +: 16] = 16'(en[b]);
                    en[b] = 0;
                end
                exp_fr[nexp] = fr;
                exp_tag[nexp] = cur_tag;
                nexp++;
            end
        end
    endtask

    // called at a negedge; holds the sample until it is taken (R8)
    task automatic send(input logic signed [11:0] v);
        bit eighth;
        in_valid = 1'b1;
        in_data = v;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        eighth = (ph == 7);
        model_push(int'(v));
        if (eighth) check(in_ready == 1'b0, "R2 R8 busy after group", 112'(in_ready), 112'(0));
        else        check(in_ready == 1'b1, "R2 ready mid group", 112'(in_ready), 112'(1));
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic wr_coef(input int bank, input int tap, input int val);
        while (!in_ready) @(negedge clk);
        coef_we = 1'b1;
        coef_bank = 3'(bank);
        coef_tap = 6'(tap);
        coef_data = 8'(val);
        @(negedge clk);
        coef_we = 1'b0;
        cf[bank][tap] = int'($signed(8'(val)));
    endtask

    task automatic load_all(input int mode);
        for (int b = 0; b < 8; b++)
            for (int t = 0; t < ((b == 0) ? 49 : 47); t++) begin
                int v;
                if (mode == 0) v = int'($signed(8'($urandom % 81))) - 40;
                else if (mode == 1) v = 127;
                else v = int'($signed(8'($urandom)));
                wr_coef(b, t, v);
            end
    endtask

    // frame monitor: R6 timing and contents
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                check(!prev_valid, "R6 pulse width", 112'(prev_valid), 112'(0));
                if (ngot < nexp) begin
                    check(frame_bins == exp_fr[ngot], exp_tag[ngot], frame_bins, exp_fr[ngot]);
                end else begin
                    check(1'b0, "R6 early frame", 112'(ngot), 112'(nexp));
                end
                ngot++;
            end
            prev_valid <= frame_valid;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 112'(0), 112'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 49; k++) xh[k] = 0;
        for (int k = 0; k < 47; k++) dh[k] = 0;
        for (int b = 0; b < 8; b++) for (int t = 0; t < 49; t++) cf[b][t] = 0;
        for (int b = 0; b < NB; b++) en[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready", 112'(in_ready), 112'(1));
        check(frame_valid == 1'b0, "R1 valid", 112'(frame_valid), 112'(0));
        check(frame_bins == '0, "R1 bins", frame_bins, '0);

        // reset coefficients are zero: bins zero
        cur_tag = "R9 zero coefs";
        for (int i = 0; i < 8 * WIN; i++) send(12'($urandom));

        // random coefficients, random samples, several windows
        load_all(0);
        cur_tag = "R3 R4 R7 random";
        for (int i = 0; i < 3 * 8 * WIN; i++) send(12'($urandom));

        // full-scale input with maximum coefficients: clamp and saturation
        load_all(1);
        cur_tag = "R5 R3 saturate";
        for (int i = 0; i < 2 * 8 * WIN; i++) send(12'sd2047);

        // alternating extremes with random full-range coefficients
        load_all(2);
        cur_tag = "R4 R7 alternating";
        for (int i = 0; i < 2 * 8 * WIN; i++) send((i % 2 == 0) ? -12'sd2048 : 12'sd2047);

        // back-to-back samples with no gaps: hold-off must not lose any
        cur_tag = "R8 back to back";
        for (int i = 0; i < 8 * WIN; i++) begin
            in_valid = 1'b1;
            in_data = 12'($urandom);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            model_push(int'(in_data));
        end
        in_valid = 1'b0;

        repeat (800) @(negedge clk);
        check(ngot == nexp, "R6 frame count", 112'(ngot), 112'(nexp));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule